// File: doc/BRIEF.md
# Outbound Parity Gate with Keyed Tag and Acknowledged Delivery

This block sits on the transmit side of a two-layer integrity unit, between a host and a network link. The host offers one data word at a time together with an even-parity bit. The block recomputes parity over the word. A word whose parity does not match is discarded, and the host gets a one-cycle soft-error alert so it can offer the word again. A word that passes is given a keyed tag by a tag-generator submodule. The data and the tag are joined into one outbound word, which is held in a register and offered to the network with a valid/ready handshake.

Once the network takes the word, the block waits for an acknowledgement from the far end. If the acknowledgement arrives, the block pulses `done_o` and is ready for the next host word. If no acknowledgement arrives within a parameter number of cycles, a host-driven select input decides what happens next. With retry selected, the held word is offered again, up to a parameter number of times. Otherwise, or once the retries are used up, the block pulses `abort_o` and returns to idle.

The tag splits the data into tag-wide blocks. Each block may be inverted and is then rotated left by an amount taken from a secret key. The rotated blocks are XORed together to give the tag.

Top module: `txg_outbound`

## Requirements
- R1: A host word is accepted when `host_valid_i` and `host_ready_o` are both high. If `host_par_i` equals the XOR of all data bits, the word is forwarded and `net_valid_o` is high from the next cycle. Otherwise the word is dropped: `perr_o` is high for exactly the next cycle and `net_valid_o` stays low.
- R2: `net_word_o` carries the accepted data in bits [DATA_W+TAG_W-1:TAG_W] and its tag in bits [TAG_W-1:0].
- R3: The tag is formed per data block i (bits [i*TAG_W +: TAG_W]). The block is inverted when key bit NBLK*SH_W+i is 1. It is then rotated left by key field [i*SH_W +: SH_W]. All blocks are XORed together. Here NBLK = DATA_W/TAG_W and SH_W = log2(TAG_W).
- R4: `host_ready_o` is high only while no transfer is outstanding. A host offer made while it is low is ignored: the held word does not change and no alert is raised.
- R5: While `net_valid_o` is high and `net_ready_i` is low, `net_valid_o` stays high and `net_word_o` stays stable.
- R6: After the network takes the word, an `ack_i` that arrives within TIMEOUT cycles makes `done_o` high for exactly one cycle. `host_ready_o` is high from that same cycle. This holds even when `ack_i` arrives in the last cycle of the window.
- R7: If TIMEOUT cycles pass after the network takes the word with no `ack_i`, `retry_en_i` is 1, and fewer than MAX_RETRY retries have been made for this word, the same word is offered to the network again in the next cycle.
- R8: If the time-out expires and R7 does not apply, `abort_o` is high for exactly one cycle and the block returns to idle without offering the word again.
- R9: `ack_i` has no effect unless the block is waiting for an acknowledgement. While the word is still being offered to the network, `ack_i` produces no `done_o` and leaves `net_valid_o` high.
- R10: After reset, `host_ready_o` is 1 and `net_valid_o`, `perr_o`, `done_o` and `abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid_i | input | 1 | Host offers a word |
| host_data_i | input | DATA_W | Host data word |
| host_par_i | input | 1 | Even-parity bit supplied with the word |
| host_ready_o | output | 1 | Block can take a host word |
| retry_en_i | input | 1 | 1: resend on time-out, 0: abort on time-out |
| key_i | input | NBLK*(SH_W+1) | Secret tag key (rotate fields low, invert bits high) |
| net_valid_o | output | 1 | Outbound word available |
| net_word_o | output | DATA_W+TAG_W | Data joined with tag |
| net_ready_i | input | 1 | Network takes the outbound word |
| ack_i | input | 1 | Acknowledgement from the far end |
| perr_o | output | 1 | One-cycle soft-error alert |
| done_o | output | 1 | One-cycle delivery-confirmed pulse |
| abort_o | output | 1 | One-cycle transfer-abandoned pulse |

## Verification
The assertions assume the following about the inputs:
- `key_i` is stable in any cycle in which a host word is accepted.
- `ack_i` is a plain level, with no required relationship to `net_ready_i`.
- Reset is applied before the first offer.

The stimulus meets these assumptions. It drives every input only at falling edges and changes the key only between transfers. It raises `ack_i` both inside and outside the wait window, so the rule that ignores an early acknowledgement is exercised. It also drives host offers while the block is busy, including words with bad parity.

// File: rtl/txg_pkg.sv
package txg_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_SEND = 2'd1,
      TX_WAIT = 2'd2
   } tx_state_e;

   function automatic int txg_key_width(input int data_w, input int tag_w);
      return (data_w / tag_w) * ($clog2(tag_w) + 1);
   endfunction

endpackage

// File: rtl/txg_parity_gate.sv
module txg_parity_gate #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              par_i,
   output logic              good_o,
   output logic              alert_o
);

   logic calc_par;

   assign calc_par = ^data_i;
   assign good_o   = (calc_par == par_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alert_o <= 1'b0;
      end else begin
         alert_o <= take_i & ~good_o;
      end
   end

   // R1: an alert only follows a taken word
   a_r1_alert_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |-> $past(take_i));

   // R1: alert is a single-cycle pulse unless another bad word is taken
   a_r1_alert_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o && !$past(take_i, 1) |-> 1'b0);

endmodule

// File: rtl/txg_tag_gen.sv
module txg_tag_gen #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 8
) (
   input  logic [DATA_W-1:0]                            data_i,
   input  logic [txg_pkg::txg_key_width(DATA_W, TAG_W)-1:0] key_i,
   output logic [TAG_W-1:0]                             tag_o
);

   localparam int NBLK = DATA_W / TAG_W;
   localparam int SH_W = $clog2(TAG_W);

   logic [TAG_W-1:0] acc [0:NBLK];

   assign acc[0] = '0;

   for (genvar g = 0; g < NBLK; g++) begin : g_blk
      logic [TAG_W-1:0]   raw;
      logic [TAG_W-1:0]   inv;
      logic [SH_W-1:0]    amt;
      logic [2*TAG_W-1:0] dbl;

      assign raw = data_i[g*TAG_W +: TAG_W];
      assign inv = key_i[NBLK*SH_W + g] ? ~raw : raw;
      assign amt = key_i[g*SH_W +: SH_W];
      assign dbl = {inv, inv} << amt;
      assign acc[g+1] = acc[g] ^ dbl[2*TAG_W-1:TAG_W];
   end

   assign tag_o = acc[NBLK];

endmodule

// File: rtl/txg_ack_tracker.sv
module txg_ack_tracker #(
   parameter int WORD_W    = 40,
   parameter int TIMEOUT   = 16,
   parameter int MAX_RETRY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              retry_en_i,
   input  logic              net_ready_i,
   input  logic              ack_i,
   output logic              idle_o,
   output logic              net_valid_o,
   output logic [WORD_W-1:0] net_word_o,
   output logic              done_o,
   output logic              abort_o
);
   import txg_pkg::*;

   localparam int TMR_W = $clog2(TIMEOUT);
   localparam int RC_W  = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

   tx_state_e         state;
   logic [TMR_W-1:0]  timer;
   logic [WORD_W-1:0] held;
   logic              timer_last;
   logic              expire;
   logic              can_retry;
   logic              bump_try;
   logic              clr_try;

   assign timer_last = (timer == TMR_W'(TIMEOUT - 1));
   assign expire     = (state == TX_WAIT) && !ack_i && timer_last;
   assign bump_try   = expire && retry_en_i && can_retry;
   assign clr_try    = (state == TX_IDLE) && load_i;

   if (MAX_RETRY > 0) begin : g_retry
      logic [RC_W-1:0] tries;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tries <= '0;
         end else if (clr_try) begin
            tries <= '0;
         end else if (bump_try) begin
            tries <= tries + 1'b1;
         end
      end

      assign can_retry = (tries < RC_W'(MAX_RETRY));

      // R7: retries never exceed the cap
      a_r7_retry_cap: assert property (@(posedge clk) disable iff (!rst_n)
         tries <= RC_W'(MAX_RETRY));
   end else begin : g_noretry
      assign can_retry = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= TX_IDLE;
         timer   <= '0;
         held    <= '0;
         done_o  <= 1'b0;
         abort_o <= 1'b0;
      end else begin
         done_o  <= 1'b0;
         abort_o <= 1'b0;
         case (state)
            TX_IDLE: begin
               if (load_i) begin
                  held  <= word_i;
                  state <= TX_SEND;
               end
            end
            TX_SEND: begin
               if (net_ready_i) begin
                  timer <= '0;
                  state <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (ack_i) begin
                  done_o <= 1'b1;
                  state  <= TX_IDLE;
               end else if (timer_last) begin
                  if (bump_try) begin
                     state <= TX_SEND;
                  end else begin
                     abort_o <= 1'b1;
                     state   <= TX_IDLE;
                  end
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign idle_o      = (state == TX_IDLE);
   assign net_valid_o = (state == TX_SEND);
   assign net_word_o  = held;

   // R5: offered word held until taken
   a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      net_valid_o && !net_ready_i |=> net_valid_o && $stable(net_word_o));

   // R6: done only follows an acknowledgement
   a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(ack_i));

   // R6: done is a one-cycle pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: abort is a one-cycle pulse and never coincides with done
   a_r8_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !done_o ##1 !abort_o);

   // R9: acknowledgement while offering does not end the offer
   a_r9_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
      net_valid_o && !net_ready_i && ack_i |=> net_valid_o && !done_o);

endmodule

// File: rtl/txg_outbound.sv
module txg_outbound #(
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 8,
   parameter int TIMEOUT   = 16,
   parameter int MAX_RETRY = 2,
   localparam int KEY_W    = txg_pkg::txg_key_width(DATA_W, TAG_W),
   localparam int WORD_W   = DATA_W + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid_i,
   input  logic [DATA_W-1:0] host_data_i,
   input  logic              host_par_i,
   output logic              host_ready_o,
   input  logic              retry_en_i,
   input  logic [KEY_W-1:0]  key_i,
   output logic              net_valid_o,
   output logic [WORD_W-1:0] net_word_o,
   input  logic              net_ready_i,
   input  logic              ack_i,
   output logic              perr_o,
   output logic              done_o,
   output logic              abort_o
);

   if (TAG_W < 2 || (TAG_W & (TAG_W - 1)) != 0) begin : g_chk_tag
      $error("TAG_W must be a power of two of at least 2");
   end
   if (DATA_W % TAG_W != 0) begin : g_chk_div
      $error("DATA_W must be a multiple of TAG_W");
   end
   if (TIMEOUT < 2) begin : g_chk_tmo
      $error("TIMEOUT must be at least 2 cycles");
   end
   if (MAX_RETRY < 0) begin : g_chk_rty
      $error("MAX_RETRY must not be negative");
   end

   logic             take;
   logic             par_good;
   logic             idle;
   logic [TAG_W-1:0] tag;

   assign host_ready_o = idle;
   assign take         = host_valid_i && idle;

   txg_parity_gate #(
      .DATA_W (DATA_W)
   ) i_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .data_i  (host_data_i),
      .par_i   (host_par_i),
      .good_o  (par_good),
      .alert_o (perr_o)
   );

   txg_tag_gen #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
   ) i_tag (
      .data_i (host_data_i),
      .key_i  (key_i),
      .tag_o  (tag)
   );

   txg_ack_tracker #(
      .WORD_W    (WORD_W),
      .TIMEOUT   (TIMEOUT),
      .MAX_RETRY (MAX_RETRY)
   ) i_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (take && par_good),
      .word_i      ({host_data_i, tag}),
      .retry_en_i  (retry_en_i),
      .net_ready_i (net_ready_i),
      .ack_i       (ack_i),
      .idle_o      (idle),
      .net_valid_o (net_valid_o),
      .net_word_o  (net_word_o),
      .done_o      (done_o),
      .abort_o     (abort_o)
   );

   // R1: a dropped word never reaches the network
   a_r1_drop_no_send: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |-> !net_valid_o);

   // R4: host side is closed while a word is offered to the network
   a_r4_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      net_valid_o |-> !host_ready_o);

   // R4: offers while busy raise no alert
   a_r4_busy_no_alert: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid_i && !host_ready_o |=> !perr_o);

   // R6: completion returns the block to idle
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o || abort_o |-> host_ready_o);

endmodule

// File: tb/test_txg_outbound.sv
`timescale 1ns/1ps
module test_txg_outbound;

   localparam int DW = 32;
   localparam int TW = 8;
   localparam int TMO = 16;
   localparam int MR = 2;
   localparam int NB = DW / TW;
   localparam int SW = $clog2(TW);
   localparam int KW = NB * (SW + 1);
   localparam int NV = 8;

   // {key, data, parity}
   localparam logic [KW+DW:0] VEC [NV] = '{
      {16'hDC21, 32'h434F4D50, 1'b0},
      {16'hDC21, 32'h434F4D50, 1'b1},
      {16'h0000, 32'hFFFFFFFF, 1'b0},
      {16'hF000, 32'hFFFFFFFF, 1'b1},
      {16'h0FFF, 32'h00000001, 1'b1},
      {16'h5A5A, 32'h00000001, 1'b0},
      {16'h3E97, 32'h80A53C7E, 1'b0},
      {16'h81C4, 32'h12345678, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_valid = 1'b0;
   logic [DW-1:0] host_data = '0;
   logic host_par = 1'b0;
   logic host_ready;
   logic retry_en = 1'b0;
   logic [KW-1:0] key = '0;
   logic net_valid;
   logic [DW+TW-1:0] net_word;
   logic net_ready = 1'b0;
   logic ack = 1'b0;
   logic perr, done, abort_p;

   int checks = 0;
   int fails = 0;

   always #2 clk = ~clk;

   txg_outbound #(.DATA_W(DW), .TAG_W(TW), .TIMEOUT(TMO), .MAX_RETRY(MR)) i_txg_outbound (
      .clk(clk), .rst_n(rst_n), .host_valid_i(host_valid), .host_data_i(host_data),
      .host_par_i(host_par), .host_ready_o(host_ready), .retry_en_i(retry_en),
      .key_i(key), .net_valid_o(net_valid), .net_word_o(net_word),
      .net_ready_i(net_ready), .ack_i(ack), .perr_o(perr), .done_o(done), .abort_o(abort_p)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [TW-1:0] ref_tag(input logic [DW-1:0] d, input logic [KW-1:0] k);
      logic [TW-1:0] t = '0;
      for (int b = 0; b < NB; b++) begin
         int r = int'(k[b*SW +: SW]);
         for (int j = 0; j < TW; j++) begin
            int s = (j - r + TW) % TW;
            t[j] = t[j] ^ d[b*TW + s] ^ k[NB*SW + b];
         end
      end
      return t;
   endfunction

   task automatic offer(input logic [DW-1:0] d, input logic p);
      @(negedge clk);
      host_valid = 1'b1; host_data = d; host_par = p;
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   task automatic handoff();
      @(negedge clk); net_ready = 1'b1;
      @(negedge clk); net_ready = 1'b0;
   endtask

   task automatic give_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      fails++; checks++;
      $display("FAIL watchdog actual %h expected %h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [DW+TW-1:0] w;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(host_ready === 1'b1 && net_valid === 1'b0 && perr === 1'b0 && done === 1'b0 && abort_p === 1'b0,
          "R10", {59'd0, host_ready, net_valid, perr, done, abort_p}, 64'h10);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R6
      for (int v = 0; v < NV; v++) begin
         logic [DW-1:0] d = VEC[v][DW:1];
         logic p = VEC[v][0];
         bit good = (^d) == p;
         key = VEC[v][KW+DW:DW+1];
         offer(d, p);
         if (good) begin
            chk(net_valid === 1'b1 && perr === 1'b0, "R1", {62'd0, net_valid, perr}, 64'h2);
            chk(net_word === {d, ref_tag(d, key)}, "R2", 64'(net_word), 64'({d, ref_tag(d, key)}));
            handoff();
            give_ack();
            chk(done === 1'b1 && host_ready === 1'b1, "R6", {62'd0, done, host_ready}, 64'h3);
            @(negedge clk);
            chk(done === 1'b0, "R6", 64'(done), 64'h0);
         end else begin
            chk(perr === 1'b1 && net_valid === 1'b0, "R1", {62'd0, perr, net_valid}, 64'h2);
            @(negedge clk);
            chk(perr === 1'b0 && host_ready === 1'b1, "R1", {62'd0, perr, host_ready}, 64'h1);
         end
      end

      // R3 known-answer: ascii word, tag 0x14
      key = 16'hDC21;
      offer(32'h434F4D50, 1'b0);
      chk(net_word[TW-1:0] === 8'h14, "R3", 64'(net_word[TW-1:0]), 64'h14);
      w = net_word;
      // R4 busy offer with bad parity ignored, R5 hold, R9 early ack ignored
      host_valid = 1'b1; host_data = 32'h00000003; host_par = 1'b1; ack = 1'b1;
      repeat (4) @(negedge clk);
      host_valid = 1'b0; ack = 1'b0;
      chk(host_ready === 1'b0 && perr === 1'b0, "R4", {62'd0, host_ready, perr}, 64'h0);
      chk(net_valid === 1'b1 && net_word === w, "R5", 64'(net_word), 64'(w));
      chk(done === 1'b0 && net_valid === 1'b1, "R9", {62'd0, done, net_valid}, 64'h1);
      // R6 ack in final window cycle wins over time-out
      handoff();
      repeat (TMO - 1) @(negedge clk);
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk(done === 1'b1 && net_valid === 1'b0 && abort_p === 1'b0, "R6", {61'd0, done, net_valid, abort_p}, 64'h4);

      // R7 retries then R8 abort
      retry_en = 1'b1;
      offer(32'hFFFFFFFF, 1'b0);
      w = net_word;
      for (int t = 0; t < MR; t++) begin
         handoff();
         repeat (TMO - 1) @(negedge clk);
         chk(net_valid === 1'b0 && abort_p === 1'b0, "R7", {62'd0, net_valid, abort_p}, 64'h0);
         @(negedge clk);
         chk(net_valid === 1'b1 && net_word === w, "R7", 64'(net_word), 64'(w));
      end
      handoff();
      repeat (TMO) @(negedge clk);
      chk(abort_p === 1'b1 && net_valid === 1'b0, "R8", {62'd0, abort_p, net_valid}, 64'h2);
      @(negedge clk);
      chk(abort_p === 1'b0 && host_ready === 1'b1, "R8", {62'd0, abort_p, host_ready}, 64'h1);

      // R8 abort on first time-out when retry disabled
      retry_en = 1'b0;
      offer(32'h00000001, 1'b1);
      handoff();
      repeat (TMO) @(negedge clk);
      chk(abort_p === 1'b1 && net_valid === 1'b0, "R8", {62'd0, abort_p, net_valid}, 64'h2);

      // R9 ack while idle gives no done
      give_ack();
      chk(done === 1'b0 && host_ready === 1'b1, "R9", {62'd0, done, host_ready}, 64'h1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule